// File: doc/BRIEF.md
# Auto-DMA stereo input stream writer

This block takes a stream of 16-bit stereo PCM words from a host DMA channel and writes them into a double-buffered input region of sound memory. The region belongs to one core. Data arrives in chunks of 512 words. The first 256 words of a chunk are the left samples and the last 256 are the right samples. Each half goes to its own sub-buffer. Both sub-buffers sit at fixed offsets inside a region whose base is derived from the core index. A write position alternates between the two halves of each sub-buffer, so playback can drain one half while the host refills the other.

Software starts a transfer with a start strobe and a byte length. Before each chunk the block checks two conditions: at least one chunk of free space must exist, and at least one chunk's worth of bytes must remain. The playback side returns free space one chunk at a time through a strobe. When a chunk is due but there is no space, the stream is back-pressured: ready stays low and no word is consumed. After each half-chunk is written, the half's address range is compared with the watch addresses of both cores. An enabled core whose watch address falls inside the range gets a sticky flag.

The host stream follows valid/ready rules. A word moves only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` depends only on internal state and never on `s_valid`. A source may hold `s_valid` high for any number of cycles while `s_ready` is low without losing or duplicating a word.

Top module: `adma_stream_in`

## Requirements
- R1: `s_ready` is high only while a chunk is in progress. A chunk begins only when the free-space level is nonzero and the remaining byte count is at least 0x400. While either condition fails, `s_ready` stays low and nothing is consumed. `s_ready` goes high on the second clock edge after a start, or after the free return that unblocks the chunk.
- R2: The region base word address is 0x2000 + (CORE_ID << 10). Words 0..255 of a chunk are written to base + wpos + k, where k is the index within the half.
- R3: Words 256..511 of a chunk are written to base + 0x200 + wpos + (k - 256). Within a half, successive writes go to successive addresses.
- R4: The write position wpos starts at 0 after reset. It advances by 0x100 modulo 0x200 after every chunk, and it persists across transfers.
- R5: The free-space level resets to FREE_CAP (default 2) and drops by one after every chunk. Each cycle with `free_ret` high adds one, and the level saturates at FREE_CAP.
- R6: The remaining byte count drops by 0x400 per chunk. When it is below 0x400 at a chunk boundary, `xfer_done` pulses for one cycle and the leftover bytes are not consumed. This pulse is visible in the second cycle after the last accepted word, or in the second cycle after a start whose length is between 2 and 0x3FF.
- R7: For each half, core i (0 or 1) sets `irq_info[2+i]` when `watch_en[i]` is high and its watch address lies in [half start, half start + 0x100). The start is inclusive and the end is exclusive. The bit is visible in the same cycle as the half's last memory write. `irq_info[1:0]` is always 0.
- R8: `irq_info[2+i]` stays set until `info_clr[i]` is high. If a set and a clear happen in the same cycle, the set wins.
- R9: If a start arrives while bit CORE_ID of `auto_ctrl` is clear and the length is at least 2, the start is ignored: no write, no ready and no `xfer_done`.
- R10: A start with a length below 2 pulses `xfer_done` in the cycle after the start edge, writes nothing, and does this whatever `auto_ctrl` holds.
- R11: Each accepted word produces exactly one memory write, `mem_we` high in the cycle after acceptance, with `mem_wdata` equal to the accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_ctrl | input | 2 | Auto-streaming enable, one bit per core |
| xfer_start | input | 1 | Start strobe, sampled while idle |
| xfer_len | input | LEN_W | Transfer length in bytes |
| s_valid | input | 1 | Host word valid |
| s_ready | output | 1 | Block can take a word |
| s_data | input | DATA_W | Host PCM word |
| free_ret | input | 1 | Playback returned one chunk of space |
| watch_en | input | 2 | Address watch enable per core |
| watch_addr0 | input | ADDR_W | Watch word address of core 0 |
| watch_addr1 | input | ADDR_W | Watch word address of core 1 |
| info_clr | input | 2 | Clear for the watch flags per core |
| mem_we | output | 1 | Sound memory write enable |
| mem_addr | output | ADDR_W | Sound memory word address |
| mem_wdata | output | DATA_W | Sound memory write data |
| xfer_done | output | 1 | Transfer finished pulse |
| irq_info | output | 4 | Watch flags in bits 3:2, bits 1:0 zero |

## Verification
A write is due one edge after the edge that accepts its word. The monitor compares every `mem_we` cycle, sampled on the falling edge, against a queue that the driver fills at the accepting edge. A write that appears when the queue is empty is therefore an error. `xfer_done` is checked exactly one falling edge after the start edge for short lengths. For chunked transfers it is checked two falling edges after the last accepting edge, with a check that it is still low one falling edge earlier. Watch flags are read after the transfer's done pulse, and stalls are confirmed by holding `s_valid` high for 30 cycles while `s_ready` is sampled on each falling edge.

// File: rtl/adma_pkg.sv
package adma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GATE  = 2'd1,
    ST_LEFT  = 2'd2,
    ST_RIGHT = 2'd3
  } adma_state_e;
endpackage

// File: rtl/adma_free_ctr.sv
module adma_free_ctr #(
  parameter int CAP = 2,
  parameter int W   = $clog2(CAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic give,
  input  logic take,
  output logic has_room
);
  logic [W-1:0] level_q;
  logic [W:0]   sum;
  logic [W-1:0] level_d;

  always_comb begin
    sum = {1'b0, level_q} - {{W{1'b0}}, take} + {{W{1'b0}}, give};
    if (sum > (W + 1)'(CAP)) level_d = W'(CAP);
    else                     level_d = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= W'(CAP);
    else        level_q <= level_d;
  end

  assign has_room = (level_q != '0);
endmodule

// File: rtl/adma_addr_gen.sv
module adma_addr_gen #(
  parameter int ADDR_W    = 20,
  parameter int POS_W     = 9,
  parameter int CNT_W     = 8,
  parameter int BASE      = 'h2000,
  parameter int RIGHT_OFS = 'h200
) (
  input  logic [POS_W-1:0]  wpos,
  input  logic              right,
  input  logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] half_start,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] side_ofs;

  always_comb begin
    side_ofs   = right ? ADDR_W'(RIGHT_OFS) : '0;
    half_start = ADDR_W'(BASE) + side_ofs + ADDR_W'(wpos);
    addr       = half_start + ADDR_W'(cnt);
  end
endmodule

// File: rtl/adma_irq_watch.sv
module adma_irq_watch #(
  parameter int ADDR_W = 20,
  parameter int SPAN   = 256,
  parameter int NCORE  = 2
) (
  input  logic                          chk,
  input  logic [ADDR_W-1:0]             start,
  input  logic [NCORE-1:0]              en,
  input  logic [NCORE-1:0][ADDR_W-1:0]  watch,
  output logic [NCORE-1:0]              hit
);
  logic [ADDR_W:0] stop;
  assign stop = {1'b0, start} + (ADDR_W + 1)'(SPAN);

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    assign hit[i] = chk && en[i] && (watch[i] >= start) &&
                    ({1'b0, watch[i]} < stop);
  end
endmodule

// File: rtl/adma_stream_in.sv
module adma_stream_in #(
  parameter int CORE_ID         = 0,
  parameter int ADDR_W          = 20,
  parameter int DATA_W          = 16,
  parameter int LEN_W           = 16,
  parameter int HALF_WORDS      = 256,
  parameter int FREE_CAP        = 2,
  parameter int REGION_BASE     = 'h2000,
  parameter int CORE_STRIDE_LOG = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        auto_ctrl,
  input  logic              xfer_start,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              free_ret,
  input  logic [1:0]        watch_en,
  input  logic [ADDR_W-1:0] watch_addr0,
  input  logic [ADDR_W-1:0] watch_addr1,
  input  logic [1:0]        info_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              xfer_done,
  output logic [3:0]        irq_info
);
  import adma_pkg::*;

  localparam int CNT_W       = $clog2(HALF_WORDS);
  localparam int POS_W       = $clog2(2 * HALF_WORDS);
  localparam int CHUNK_BYTES = 4 * HALF_WORDS;
  localparam int RIGHT_OFS   = 2 * HALF_WORDS;
  localparam int BASE        = REGION_BASE + (CORE_ID << CORE_STRIDE_LOG);
  localparam logic [1:0] SEL = 2'(1 << CORE_ID);

  adma_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [POS_W-1:0]  wpos_q;
  logic [LEN_W-1:0]  rem_q;
  logic              done_q;
  logic [1:0]        info_q;

  logic              auto_on;
  logic              accept;
  logic              last_word;
  logic              chunk_end;
  logic              has_room;
  logic [ADDR_W-1:0] half_start;
  logic [ADDR_W-1:0] wr_addr;
  logic [1:0]        hit;
  logic [1:0][ADDR_W-1:0] watch_vec;

  assign auto_on   = |(auto_ctrl & SEL);
  assign s_ready   = (state_q == ST_LEFT) || (state_q == ST_RIGHT);
  assign accept    = s_valid && s_ready;
  assign last_word = accept && (cnt_q == CNT_W'(HALF_WORDS - 1));
  assign chunk_end = last_word && (state_q == ST_RIGHT);
  assign watch_vec = {watch_addr1, watch_addr0};

  adma_free_ctr #(.CAP(FREE_CAP)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .give     (free_ret),
    .take     (chunk_end),
    .has_room (has_room)
  );

  adma_addr_gen #(
    .ADDR_W    (ADDR_W),
    .POS_W     (POS_W),
    .CNT_W     (CNT_W),
    .BASE      (BASE),
    .RIGHT_OFS (RIGHT_OFS)
  ) u_addr (
    .wpos       (wpos_q),
    .right      (state_q == ST_RIGHT),
    .cnt        (cnt_q),
    .half_start (half_start),
    .addr       (wr_addr)
  );

  adma_irq_watch #(
    .ADDR_W (ADDR_W),
    .SPAN   (HALF_WORDS),
    .NCORE  (2)
  ) u_watch (
    .chk   (last_word),
    .start (half_start),
    .en    (watch_en),
    .watch (watch_vec),
    .hit   (hit)
  );

  // sequencing of a transfer: idle -> gate -> left half -> right half -> gate
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wpos_q  <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (xfer_start) begin
            if (xfer_len < LEN_W'(2)) begin
              done_q <= 1'b1;
            end else if (auto_on) begin
              rem_q   <= xfer_len;
              state_q <= ST_GATE;
            end
          end
        end
        ST_GATE: begin
          if (rem_q < LEN_W'(CHUNK_BYTES)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (has_room) begin
            cnt_q   <= '0;
            state_q <= ST_LEFT;
          end
        end
        ST_LEFT: begin
          if (accept) cnt_q <= cnt_q + 1'b1;
          if (last_word) begin
            cnt_q   <= '0;
            state_q <= ST_RIGHT;
          end
        end
        ST_RIGHT: begin
          if (accept) cnt_q <= cnt_q + 1'b1;
          if (last_word) begin
            cnt_q   <= '0;
            rem_q   <= rem_q - LEN_W'(CHUNK_BYTES);
            wpos_q  <= wpos_q + POS_W'(HALF_WORDS);
            state_q <= ST_GATE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // registered memory write port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= accept;
      if (accept) begin
        mem_addr  <= wr_addr;
        mem_wdata <= s_data;
      end
    end
  end

  // sticky watch flags, set has priority over clear
  for (genvar i = 0; i < 2; i++) begin : g_info
    always_ff @(posedge clk) begin
      if (!rst_n)          info_q[i] <= 1'b0;
      else if (hit[i])     info_q[i] <= 1'b1;
      else if (info_clr[i]) info_q[i] <= 1'b0;
    end
  end

  assign xfer_done = done_q;
  assign irq_info  = {info_q, 2'b00};
endmodule

// File: rtl/adma_stream_in_chk.sv
module adma_stream_in_chk #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int BASE_ADDR  = 'h2000,
  parameter int HALF_WORDS = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] s_data,
  input logic [1:0]        info_clr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              xfer_done,
  input logic [3:0]        irq_info
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_ADDR + 4 * HALF_WORDS);
  localparam logic [ADDR_W-1:0] HMASK = ADDR_W'(HALF_WORDS - 1);

  // R11: a write only follows an accepted word
  assert_write_follows_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(s_valid && s_ready));

  // R11: written data is the accepted word
  assert_write_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == $past(s_data)));

  // R2: writes stay inside the core's region
  assert_addr_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr >= LO) && (mem_addr < HI)));

  // R3: successive writes within a half step by one word
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && ((mem_addr & HMASK) != '0)) |->
      (mem_addr == $past(mem_addr) + 1'b1));

  // R1: no word is taken in the cycle the transfer reports done
  assert_no_ready_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !s_ready);

  // R8: flags hold until cleared
  assert_info0_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_info[2] && !info_clr[0]) |=> irq_info[2]);
  assert_info1_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_info[3] && !info_clr[1]) |=> irq_info[3]);
endmodule

bind adma_stream_in adma_stream_in_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .BASE_ADDR  (REGION_BASE + (CORE_ID << CORE_STRIDE_LOG)),
  .HALF_WORDS (HALF_WORDS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .s_data    (s_data),
  .info_clr  (info_clr),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .xfer_done (xfer_done),
  .irq_info  (irq_info)
);

// File: tb/sim_adma_stream_in.sv
module sim_adma_stream_in;
  localparam int CORE  = 1;
  localparam int BASE  = 'h2000 + (CORE << 10);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  auto_ctrl = 2'b00;
  logic        xfer_start = 1'b0;
  logic [15:0] xfer_len = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        free_ret = 1'b0;
  logic [1:0]  watch_en = 2'b00;
  logic [19:0] watch_addr0 = '0;
  logic [19:0] watch_addr1 = '0;
  logic [1:0]  info_clr = 2'b00;
  logic        mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        xfer_done;
  logic [3:0]  irq_info;

  int total = 0;
  int bad = 0;
  int wpos_m = 0;
  logic [15:0] pat = 16'h1357;
  logic [35:0] exp_q[$];

  adma_stream_in #(.CORE_ID(CORE)) u0 (
    .clk(clk), .rst_n(rst_n), .auto_ctrl(auto_ctrl), .xfer_start(xfer_start),
    .xfer_len(xfer_len), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .free_ret(free_ret), .watch_en(watch_en), .watch_addr0(watch_addr0),
    .watch_addr1(watch_addr1), .info_clr(info_clr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .xfer_done(xfer_done),
    .irq_info(irq_info)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every write is compared with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R11 unexpected write actual=%h:%h expected=none", mem_addr, mem_wdata);
      end else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        if ({mem_addr, mem_wdata} !== e) begin
          bad++;
          $display("FAIL R2 R3 write actual=%h:%h expected=%h:%h",
                   mem_addr, mem_wdata, e[35:16], e[15:0]);
        end
      end
    end
  end

  task automatic put_word(input logic [19:0] a, input logic [15:0] d);
    s_valid = 1'b1;
    s_data  = d;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back({a, d});
    @(negedge clk);
  endtask

  task automatic send_chunk();
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < 256; k++) begin
        put_word(20'(BASE + h * 'h200 + wpos_m + k), pat);
        pat = pat + 16'h0101;
      end
    end
    s_valid = 1'b0;
    wpos_m = (wpos_m + 'h100) % 'h200;
  endtask

  task automatic start_xfer(input logic [15:0] len);
    xfer_start = 1'b1;
    xfer_len   = len;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic pulse_free(input int n);
    for (int i = 0; i < n; i++) begin
      free_ret = 1'b1;
      @(negedge clk);
    end
    free_ret = 1'b0;
  endtask

  task automatic hold_stalled(input string req, input int n);
    s_valid = 1'b1;
    for (int i = 0; i < n; i++) begin
      chk(req, {31'd0, s_ready}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic check_done_after_chunk(input string req);
    chk(req, {31'd0, xfer_done}, 32'd0);
    @(negedge clk);
    chk(req, {31'd0, xfer_done}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 reset ready", {31'd0, s_ready}, 32'd0);
    chk("R11 reset we", {31'd0, mem_we}, 32'd0);
    chk("R6 reset done", {31'd0, xfer_done}, 32'd0);
    chk("R7 reset info", {28'd0, irq_info}, 32'd0);

    // R10: short length finishes at once, auto mode off
    start_xfer(16'd1);
    chk("R10 short done", {31'd0, xfer_done}, 32'd1);
    @(negedge clk);
    chk("R10 short done pulse", {31'd0, xfer_done}, 32'd0);

    // R9: only the other core's auto bit set -> start ignored
    auto_ctrl = 2'b01;
    start_xfer(16'h0400);
    s_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      chk("R9 ignored ready", {31'd0, s_ready}, 32'd0);
      chk("R9 ignored done", {31'd0, xfer_done}, 32'd0);
      @(negedge clk);
    end
    s_valid = 1'b0;

    // two chunks, watch hits on core 0 (left start) and core 1 (second left)
    auto_ctrl   = 2'b10;
    watch_en    = 2'b11;
    watch_addr0 = 20'(BASE);
    watch_addr1 = 20'(BASE + 'h100);
    start_xfer(16'h0800);
    send_chunk();
    send_chunk();
    check_done_after_chunk("R6 done after two chunks");
    chk("R7 info both cores", {28'd0, irq_info}, 32'h0000000C);
    chk("R2 R3 queue drained", exp_q.size(), 32'd0);
    repeat (5) @(negedge clk);
    chk("R8 info held", {28'd0, irq_info}, 32'h0000000C);
    info_clr = 2'b11;
    @(negedge clk);
    info_clr = 2'b00;
    chk("R8 info cleared", {28'd0, irq_info}, 32'd0);

    // free space exhausted: stall, then one return releases a chunk
    watch_en    = 2'b10;
    watch_addr0 = 20'(BASE);
    watch_addr1 = 20'(BASE + 'h300);
    start_xfer(16'h0400);
    hold_stalled("R1 R5 stall no space", 30);
    s_valid = 1'b0;
    pulse_free(1);
    send_chunk();
    check_done_after_chunk("R6 done after one chunk");
    chk("R7 exclusive end and disabled core", {28'd0, irq_info}, 32'd0);

    // saturation: four returns give only FREE_CAP=2 chunks
    pulse_free(4);
    watch_addr1 = 20'(BASE + 'h200);
    start_xfer(16'h1000);
    send_chunk();
    send_chunk();
    hold_stalled("R5 saturated at cap", 30);
    s_valid = 1'b0;
    pulse_free(2);
    send_chunk();
    send_chunk();
    check_done_after_chunk("R6 done after four chunks");
    chk("R7 right start inclusive", {28'd0, irq_info}, 32'h00000008);
    chk("R4 wrap position", wpos_m, 32'h100);

    // R6: length between 2 and 0x3FF finishes without writes
    start_xfer(16'd3);
    chk("R6 tiny not yet done", {31'd0, xfer_done}, 32'd0);
    @(negedge clk);
    chk("R6 tiny done", {31'd0, xfer_done}, 32'd1);

    // R6: tail below one chunk is left unconsumed
    pulse_free(2);
    start_xfer(16'h0500);
    send_chunk();
    check_done_after_chunk("R6 tail done");
    hold_stalled("R6 tail unconsumed", 10);
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 no extra writes", exp_q.size(), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule